// File: doc/BRIEF.md
# Logic Self-Test Pattern Sequencer with Signature Compaction

This block runs a logic self-test with no stimulus from outside the chip. A 32-bit linear-feedback pattern source drives the scan inputs of a parameterised number of parallel scan chains through a small XOR phase network. A 32-bit multiple-input signature register compacts the chain outputs. A sequencer alternates shift phases, one for each cycle of the longest chain, with single-cycle capture pulses. It does this for a pattern count that is loaded at start. After the final unload it compares the signature with an expected value.

Software or a boot sequencer sets the seed, the pattern count and the expected signature, then pulses `start`. The first shift phase only loads the chains, so the result never depends on flip-flop contents before the test. After the last capture, one extra shift phase unloads the final responses. A fixed seed and pattern count always give the same signature. Chain counts above 32 are XOR-folded onto the 32 register inputs, so 32-chain and 128-chain arrays use the same compactor.

Top module: `lbist_ctrl`

## Requirements
- R1: While `rst_n` is low, and after it rises until a start, `scan_en`, `capture`, `busy`, `done` and `pass` are all 0.
- R2: The pattern source is a 32-bit register p. On each shift cycle it becomes {p[30:0], p[31]^p[21]^p[1]^p[0]}. Chain i receives p[i%32] when i<32, and p[i%32]^p[(i%32+7*(i/32))%32] otherwise. The chains shift on every cycle in which `scan_en` is high.
- R3: An accepted start loads p with `seed`. An all-zero seed is replaced by 32'h0000_0001, so p is never zero.
- R4: After an accepted start with pattern count N, the block gives CHAIN_LEN shift cycles and then one capture cycle, N times over, then one final run of CHAIN_LEN shift cycles. `done` rises on the sample (N+1)*CHAIN_LEN+N+1 cycles after start. There are exactly N single-cycle capture pulses, and `capture` is never high with `scan_en`.
- R5: An accepted start clears the signature to 0. The shift cycles of the first phase do not change it. In every later shift cycle it becomes {m[30:0], m[31]^m[21]^m[1]^m[0]} ^ f, where f[j] is the XOR of `chain_so[k]` over all k with k%32 == j.
- R6: `pass` is high only while `done` is high and `signature` equals the `sig_expect` value latched at start. `done`, `pass` and `signature` hold until the next accepted start.
- R7: A `start` pulse while `busy` is high is ignored. The run length and the signature are unchanged.
- R8: Repeated runs with the same seed and pattern count give identical signatures.
- R9: A pattern count of 0 gives one load phase with no capture. `done` comes CHAIN_LEN+1 cycles after start, with a signature of 0.
- R10: NUM_CHAINS is a parameter (32 and 128 both supported). With 128 chains, all four chain groups feed the fold of R5.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | One-cycle request that begins a test run |
| pat_count | input | PAT_W | Number of capture patterns, sampled at start |
| seed | input | 32 | Pattern source seed, sampled at start |
| sig_expect | input | 32 | Expected signature, sampled at start |
| chain_si | output | NUM_CHAINS | Scan-in bit for each chain |
| chain_so | input | NUM_CHAINS | Scan-out bit from each chain |
| scan_en | output | 1 | Chains shift this cycle |
| capture | output | 1 | Chains capture functional response this cycle |
| busy | output | 1 | Run in progress |
| done | output | 1 | Final unload complete |
| pass | output | 1 | Done and signature equals expected |
| signature | output | 32 | Compacted response |

## Verification
The start pulse is sampled on one edge, and the first shift cycle is visible at the following negative edge. From that sample the bench counts cycles and expects `done` at exactly (N+1)*CHAIN_LEN+N+1. The tally of `scan_en` and `capture` samples must come to (N+1)*CHAIN_LEN and N. The expected signature comes from a cycle-level reference of the pattern source, the chain model and the compactor. The bench compares it against the `signature` and `pass` sampled on the cycle `done` first appears, and again a few cycles later to confirm they hold. A second start is injected in the fifth cycle of a run, and the bench checks that the cycle count and the signature are unchanged.

// File: rtl/lbist_pkg.sv
// Package lbist_pkg: shared state type, widths and the polynomial step used by
// both the pattern source and the signature register.
// Assumes a 32-bit register and the primitive polynomial x^32+x^22+x^2+x+1.
package lbist_pkg;

    localparam int          SIG_W         = 32;
    localparam logic [31:0] SEED_FALLBACK = 32'h0000_0001;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_SHIFT,
        ST_CAPT,
        ST_DONE
    } lbist_st_e;

    // One Fibonacci step, feedback from taps 31, 21, 1, 0 into bit 0.
    function automatic logic [SIG_W-1:0] lfsr_step(input logic [SIG_W-1:0] s);
        return {s[SIG_W-2:0], s[31] ^ s[21] ^ s[1] ^ s[0]};
    endfunction

endpackage

// File: rtl/lbist_prpg.sv
// Module lbist_prpg: 32-bit pseudo-random pattern source with an XOR phase
// network spreading its state over NUM_CHAINS scan inputs.
// Assumes NUM_CHAINS <= 1024 so every group offset 7*g mod 32 is nonzero.
module lbist_prpg
    import lbist_pkg::*;
#(
    parameter int NUM_CHAINS = 32
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  load,
    input  logic [SIG_W-1:0]      seed,
    input  logic                  advance,
    output logic [SIG_W-1:0]      state_o,
    output logic [NUM_CHAINS-1:0] chain_si
);

    logic [SIG_W-1:0] state_q;

    // Reseed on load (zero seed replaced), step once per shift cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= SEED_FALLBACK;
        end else if (load) begin
            state_q <= (seed == '0) ? SEED_FALLBACK : seed;
        end else if (advance) begin
            state_q <= lfsr_step(state_q);
        end
    end

    assign state_o = state_q;

    // Phase network: group 0 taps directly, later groups XOR a shifted tap.
    for (genvar gi = 0; gi < NUM_CHAINS; gi++) begin : g_phase
        localparam int J = gi % SIG_W;
        localparam int G = gi / SIG_W;
        if (G == 0) begin : g_direct
            assign chain_si[gi] = state_q[J];
        end else begin : g_mixed
            localparam int K = (J + 7 * G) % SIG_W;
            assign chain_si[gi] = state_q[J] ^ state_q[K];
        end
    end

endmodule

// File: rtl/lbist_misr.sv
// Module lbist_misr: 32-bit multiple-input signature register. Chain outputs
// are XOR-folded so that chain k lands on input k mod 32.
// Assumes clear has priority over enable.
module lbist_misr
    import lbist_pkg::*;
#(
    parameter int NUM_CHAINS = 32
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  clear,
    input  logic                  enable,
    input  logic [NUM_CHAINS-1:0] chain_so,
    output logic [SIG_W-1:0]      sig_o
);

    logic [SIG_W-1:0] fold;
    logic [SIG_W-1:0] sig_q;

    // Fold any number of chain outputs onto the register width.
    always_comb begin
        fold = '0;
        for (int k = 0; k < NUM_CHAINS; k++) begin
            fold[k % SIG_W] = fold[k % SIG_W] ^ chain_so[k];
        end
    end

    // Clear at start, compact on enabled shift cycles.
    always_ff @(posedge clk) begin
        if (!rst_n || clear) begin
            sig_q <= '0;
        end else if (enable) begin
            sig_q <= lfsr_step(sig_q) ^ fold;
        end
    end

    assign sig_o = sig_q;

endmodule

// File: rtl/lbist_seq.sv
// Module lbist_seq: sequences load, shift and capture phases for a pattern
// count latched at start, then ends with an unload-only phase.
// Assumes CHAIN_LEN >= 2; a start while busy is ignored.
module lbist_seq
    import lbist_pkg::*;
#(
    parameter int CHAIN_LEN = 8,
    parameter int PAT_W     = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic [PAT_W-1:0] pat_count,
    output logic             load,
    output logic             shift_en,
    output logic             capture,
    output logic             compact_en,
    output logic             busy,
    output logic             done
);

    localparam int            CNT_W = $clog2(CHAIN_LEN);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(CHAIN_LEN - 1);

    lbist_st_e        state_q;
    logic [CNT_W-1:0] cnt_q;
    logic [PAT_W-1:0] pats_q;
    logic [PAT_W-1:0] captured_q;

    assign busy       = (state_q == ST_SHIFT) || (state_q == ST_CAPT);
    assign load       = start && !busy;
    assign shift_en   = (state_q == ST_SHIFT);
    assign capture    = (state_q == ST_CAPT);
    assign done       = (state_q == ST_DONE);
    assign compact_en = shift_en && (captured_q != '0);

    // Phase state machine with shift counter and capture tally.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q    <= ST_IDLE;
            cnt_q      <= '0;
            pats_q     <= '0;
            captured_q <= '0;
        end else if (load) begin
            state_q    <= ST_SHIFT;
            cnt_q      <= '0;
            pats_q     <= pat_count;
            captured_q <= '0;
        end else begin
            case (state_q)
                ST_SHIFT: begin
                    if (cnt_q == LAST) begin
                        cnt_q   <= '0;
                        state_q <= (captured_q == pats_q) ? ST_DONE : ST_CAPT;
                    end else begin
                        cnt_q <= cnt_q + 1'b1;
                    end
                end
                ST_CAPT: begin
                    captured_q <= captured_q + 1'b1;
                    state_q    <= ST_SHIFT;
                end
                default: ;
            endcase
        end
    end

endmodule

// File: rtl/lbist_ctrl.sv
// Module lbist_ctrl: top of the logic self-test controller. Wires the pattern
// source, sequencer and signature register, latches the expected signature
// and forms pass. Assumes the chains under test are external to this block.
module lbist_ctrl
    import lbist_pkg::*;
#(
    parameter int NUM_CHAINS = 32,
    parameter int CHAIN_LEN  = 8,
    parameter int PAT_W      = 16
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  start,
    input  logic [PAT_W-1:0]      pat_count,
    input  logic [SIG_W-1:0]      seed,
    input  logic [SIG_W-1:0]      sig_expect,
    output logic [NUM_CHAINS-1:0] chain_si,
    input  logic [NUM_CHAINS-1:0] chain_so,
    output logic                  scan_en,
    output logic                  capture,
    output logic                  busy,
    output logic                  done,
    output logic                  pass,
    output logic [SIG_W-1:0]      signature
);

    logic             load;
    logic             compact_en;
    logic [SIG_W-1:0] prpg_q;
    logic [SIG_W-1:0] expect_q;

    lbist_seq #(
        .CHAIN_LEN (CHAIN_LEN),
        .PAT_W     (PAT_W)
    ) u_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .start      (start),
        .pat_count  (pat_count),
        .load       (load),
        .shift_en   (scan_en),
        .capture    (capture),
        .compact_en (compact_en),
        .busy       (busy),
        .done       (done)
    );

    lbist_prpg #(
        .NUM_CHAINS (NUM_CHAINS)
    ) u_prpg (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (load),
        .seed     (seed),
        .advance  (scan_en),
        .state_o  (prpg_q),
        .chain_si (chain_si)
    );

    lbist_misr #(
        .NUM_CHAINS (NUM_CHAINS)
    ) u_misr (
        .clk      (clk),
        .rst_n    (rst_n),
        .clear    (load),
        .enable   (compact_en),
        .chain_so (chain_so),
        .sig_o    (signature)
    );

    // Hold the expected signature for the whole run.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            expect_q <= '0;
        end else if (load) begin
            expect_q <= sig_expect;
        end
    end

    assign pass = done && (signature == expect_q);

endmodule

// File: rtl/lbist_ctrl_chk.sv
// Module lbist_ctrl_chk: temporal checks on the controller, bound to every
// lbist_ctrl instance. Assumes synchronous active-low reset.
module lbist_ctrl_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        start,
    input logic        busy,
    input logic        scan_en,
    input logic        capture,
    input logic        done,
    input logic        pass,
    input logic [31:0] signature,
    input logic [31:0] prpg_state
);

    AST_PRPG_NONZERO: assert property (@(posedge clk) disable iff (!rst_n)
        prpg_state != 32'h0);                                          // R3

    AST_CAPTURE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        capture |=> !capture);                                         // R4

    AST_CAPTURE_AFTER_SHIFT: assert property (@(posedge clk) disable iff (!rst_n)
        capture |-> $past(scan_en));                                   // R4

    AST_START_CLEARS_SIG: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !busy) |=> (signature == 32'h0));                    // R5

    AST_IDLE_SIG_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && !start) |=> $stable(signature));                     // R6

    AST_PASS_NEEDS_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        pass |-> done);                                                // R6

    AST_BUSY_START_KEEPS_RUN: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && start && scan_en) |=> (busy || done));                // R7

endmodule

bind lbist_ctrl lbist_ctrl_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .start      (start),
    .busy       (busy),
    .scan_en    (scan_en),
    .capture    (capture),
    .done       (done),
    .pass       (pass),
    .signature  (signature),
    .prpg_state (prpg_q)
);

// File: tb/lbist_ctrl_tb.sv
`timescale 1ns/1ps
// Bench lbist_ctrl_tb: 128 chains of 8 bits modelled around the controller;
// expected signatures come from a cycle-level reference built from R2/R5.
module lbist_ctrl_tb;

    localparam int NC    = 128;
    localparam int L     = 8;
    localparam int PW    = 16;
    localparam int LIMIT = 20000;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          start = 1'b0;
    logic [PW-1:0] pat_count = '0;
    logic [31:0]   seed = '0;
    logic [31:0]   sig_expect = '0;
    logic [NC-1:0] chain_si;
    logic [NC-1:0] chain_so;
    logic          scan_en, capture, busy, done, pass;
    logic [31:0]   signature;

    int n_checks = 0;
    int n_fail   = 0;

    always #2 clk = ~clk;

    lbist_ctrl #(.NUM_CHAINS(NC), .CHAIN_LEN(L), .PAT_W(PW)) u_dut (
        .clk(clk), .rst_n(rst_n), .start(start), .pat_count(pat_count),
        .seed(seed), .sig_expect(sig_expect), .chain_si(chain_si),
        .chain_so(chain_so), .scan_en(scan_en), .capture(capture),
        .busy(busy), .done(done), .pass(pass), .signature(signature)
    );

    // Circuit-under-test model: chains plus a capture function.
    function automatic logic [L-1:0] cap_fn(input logic [L-1:0] a,
                                            input logic [L-1:0] b, input int i);
        return a ^ {b[0], b[L-1:1]} ^ L'(i * 3 + 1);
    endfunction

    logic [L-1:0] ch [NC];
    initial for (int i = 0; i < NC; i++) ch[i] = L'(i * 37 + 5);

    always @(posedge clk) begin
        for (int i = 0; i < NC; i++) begin
            if (scan_en)      ch[i] <= {ch[i][L-2:0], chain_si[i]};
            else if (capture) ch[i] <= cap_fn(ch[i], ch[(i + 1) % NC], i);
        end
    end
    for (genvar gi = 0; gi < NC; gi++) begin : g_so
        assign chain_so[gi] = ch[gi][L-1];
    end

    // Reference model from R2, R3, R5.
    function automatic logic [31:0] step32(input logic [31:0] s);
        return {s[30:0], s[31] ^ s[21] ^ s[1] ^ s[0]};
    endfunction

    function automatic logic [31:0] golden(input logic [31:0] sd, input int n);
        logic [L-1:0] r [NC];
        logic [L-1:0] t [NC];
        logic [31:0]  p, m, f;
        logic         si;
        p = (sd == 0) ? 32'h1 : sd;
        m = '0;
        for (int i = 0; i < NC; i++) r[i] = '0;
        for (int ph = 0; ph <= n; ph++) begin
            for (int c = 0; c < L; c++) begin
                if (ph > 0) begin
                    f = '0;
                    for (int k = 0; k < NC; k++) f[k % 32] ^= r[k][L-1];
                    m = step32(m) ^ f;
                end
                for (int i = 0; i < NC; i++) begin
                    si = (i < 32) ? p[i % 32]
                                  : p[i % 32] ^ p[(i % 32 + 7 * (i / 32)) % 32];
                    r[i] = {r[i][L-2:0], si};
                end
                p = step32(p);
            end
            if (ph < n) begin
                for (int i = 0; i < NC; i++) t[i] = r[i];
                for (int i = 0; i < NC; i++) r[i] = cap_fn(t[i], t[(i + 1) % NC], i);
            end
        end
        return m;
    endfunction

    task automatic check(input bit ok, input string req, input logic [31:0] act,
                         input logic [31:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    int          r_cyc, r_sh, r_cp;
    logic [31:0] r_sig;
    logic        r_pass;

    // One run: start at a negedge, sample every negedge until done.
    task automatic run(input logic [31:0] sd, input int n, input logic [31:0] ex,
                       input bit mid_start);
        @(negedge clk);
        seed = sd; pat_count = PW'(n); sig_expect = ex; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        r_cyc = 1; r_sh = 0; r_cp = 0;
        while (!done && r_cyc < LIMIT) begin
            if (scan_en) r_sh++;
            if (capture) r_cp++;
            if (scan_en && capture) check(1'b0, "R4 shift/capture overlap", 1, 0);
            start = (mid_start && r_cyc == 5);
            @(negedge clk);
            r_cyc++;
        end
        start = 1'b0;
        if (r_cyc >= LIMIT) check(1'b0, "R4 run never finished", r_cyc, 0);
        r_sig = signature; r_pass = pass;
    endtask

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog actual=expired expected=finish");
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end

    logic [31:0] g, g_first;
    logic [31:0] seeds [3];

    initial begin
        seeds[0] = 32'hACE1_2345; seeds[1] = 32'h0000_0001; seeds[2] = 32'hFFFF_FFFF;
        repeat (3) @(negedge clk);
        // R1 reset state
        check({scan_en, capture, busy, done, pass} == 5'b0, "R1 in reset",
              {27'b0, scan_en, capture, busy, done, pass}, 0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        check({scan_en, capture, busy, done, pass} == 5'b0, "R1 after reset",
              {27'b0, scan_en, capture, busy, done, pass}, 0);

        // R2 R4 R5 R6 R10 sweep over pattern counts and seeds
        for (int s = 0; s < 3; s++) begin
            for (int n = 0; n <= 5; n++) begin
                g = golden(seeds[s], n);
                run(seeds[s], n, g, 1'b0);
                check(r_cyc == (n + 1) * L + n + 1, "R4 done timing", r_cyc, (n + 1) * L + n + 1);
                check(r_sh == (n + 1) * L, "R4 shift count", r_sh, (n + 1) * L);
                check(r_cp == n, "R4 capture count", r_cp, n);
                check(r_sig == g, "R2 R5 R10 signature", r_sig, g);
                check(r_pass, "R6 pass on match", r_pass, 1);
                if (n == 0) check(r_sig == 0, "R9 zero patterns", r_sig, 0);
            end
        end

        // R6 mismatch and hold
        g = golden(32'h1357_9BDF, 4);
        run(32'h1357_9BDF, 4, g ^ 32'h0000_0100, 1'b0);
        check(!r_pass, "R6 pass low on mismatch", r_pass, 0);
        check(done, "R6 done on mismatch", done, 1);
        repeat (3) @(negedge clk);
        check(done && signature == g && !pass, "R6 hold after done", signature, g);

        // R3 zero seed equals seed 1
        g = golden(32'h1, 3);
        run(32'h0, 3, g, 1'b0);
        check(r_sig == g, "R3 zero seed fallback", r_sig, g);
        check(r_pass, "R3 zero seed pass", r_pass, 1);

        // R8 determinism over repeated runs
        g = golden(32'h5A5A_0F0F, 6);
        run(32'h5A5A_0F0F, 6, g, 1'b0);
        g_first = r_sig;
        run(32'h5A5A_0F0F, 6, g, 1'b0);
        check(r_sig == g_first, "R8 repeat signature", r_sig, g_first);
        check(r_sig == g, "R8 repeat golden", r_sig, g);

        // R7 start while busy is ignored
        g = golden(32'hDEAD_0001, 3);
        run(32'hDEAD_0001, 3, g, 1'b1);
        check(r_cyc == 4 * L + 3 + 1, "R7 run length kept", r_cyc, 4 * L + 4);
        check(r_sig == g, "R7 signature kept", r_sig, g);

        // R9 explicit zero-count run
        run(32'h2222_3333, 0, 32'h0, 1'b0);
        check(r_cyc == L + 1 && r_cp == 0 && r_sig == 0, "R9 load only", r_sig, 0);

        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end

endmodule